// File: doc/BRIEF.md
# Coprocessor Interrupt Control and Status Register

This block is the host-visible control and status word for a coprocessor interface. It collects three interrupt sources: the coprocessor itself, the auxiliary-memory DMA engine and the audio DMA engine. Each source has a sticky flag that is raised by a pulse and cleared when software writes a 1 to it. Each flag has an enable bit in the position directly above it. The block combines the enabled, pending flags into one registered interrupt line toward the host processor.

The same word carries the coprocessor run controls (reset, halt, init and a software-asserted interrupt request), which are stored exactly as written. It also carries a read-only busy bit that follows a start/done handshake from the auxiliary-memory DMA engine. Completion of that DMA raises its interrupt flag. A write with the reset bit set sends a one-cycle clear pulse to the neighbouring audio DMA control register. Any bits that the coprocessor core owns are named by a parameter mask, and on read they are taken from a side input.

Bit map: 0 reset, 1 assert-interrupt, 2 halt, 3 coprocessor flag, 4 its enable, 5 auxiliary DMA flag, 6 its enable, 7 audio DMA flag, 8 its enable, 9 init, 10 DMA busy, 11 to 15 always zero.

Top module: `icsr_top`

## Requirements
- R1: While reset is held and right after it, the read word is 16'h0004 (halt bit 2 set, everything else 0), and both intOut and audioDmaClr are 0.
- R2: A write stores bits 0, 1, 2, 4, 6, 8 and 9 straight from wrData. The new value shows on rdData in the cycle after the write edge.
- R3: A pulse on setCop, setAram or setAid sets bit 3, 5 or 7 respectively, and the flag stays set. A write with 0 in a flag position leaves that flag unchanged.
- R4: A write with 1 in flag position 3, 5 or 7 clears that flag and no other flag.
- R5: When a flag is set by a pulse (or by DMA completion) in the same cycle as a write-1-clear of that flag, the flag ends up set.
- R6: intOut equals the OR, over the three sources, of flag AND its enable bit one position above. It follows any change of the word exactly one clock later.
- R7: A write with bit 0 set drives audioDmaClr high for exactly the one cycle after the write edge. It stays 0 otherwise.
- R8: dmaStart sets busy bit 10 at the next edge. Writes to bit 10 have no effect on it.
- R9: dmaDone while busy clears bit 10 and sets flag bit 5 at the same edge. dmaDone while not busy changes nothing.
- R10: Bits 11 to 15 read 0 whatever is written.
- R11: Bits named in parameter COP_MASK read from copBits instead of from the stored word.
- R12: dmaStart and dmaDone together while busy set flag bit 5 and leave bit 10 at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 16 | Register write data |
| setCop | input | 1 | Coprocessor interrupt set pulse |
| setAram | input | 1 | Auxiliary-memory DMA interrupt set pulse |
| setAid | input | 1 | Audio DMA interrupt set pulse |
| dmaStart | input | 1 | Auxiliary-memory DMA started |
| dmaDone | input | 1 | Auxiliary-memory DMA finished |
| copBits | input | 16 | Coprocessor-owned bit values merged on read |
| rdData | output | 16 | Current register read value |
| intOut | output | 1 | Combined interrupt request to the host |
| audioDmaClr | output | 1 | Clear pulse for the audio DMA control register |

## Verification
A corrupted flag or enable bit shows on rdData in the very cycle after the edge that stored it. One edge later the same fault shows as a wrong level on intOut, so the sweep over all flag and enable combinations checks both ports at fixed offsets. A busy bit stuck in the wrong state shows on bit 10 at once. Its link to the DMA flag shows when completion fails to raise bit 5 in that same cycle, or raises it while idle. A misordered set/clear priority only shows in the collision cycle, so that cycle is driven on purpose.

// File: rtl/icsr_pkg.sv
`timescale 1ns/1ps
package icsr_pkg;
  localparam int REG_W  = 16;
  localparam int N_SRC  = 3;
  localparam int B_RST  = 0;
  localparam int B_AINT = 1;
  localparam int B_HALT = 2;
  localparam int B_FLAG0 = 3;   // flag of source i at B_FLAG0 + 2*i, enable one above
  localparam int B_INIT = 9;
  localparam int B_BUSY = 10;

  localparam logic [REG_W-1:0] CTL_BITS  = 16'h0357;
  localparam logic [REG_W-1:0] FLAG_BITS = 16'h00A8;
  localparam logic [REG_W-1:0] RESET_VAL = 16'h0004;

  typedef struct packed {
    logic             ctlWr;
    logic [REG_W-1:0] ctlData;
    logic [N_SRC-1:0] setFlag;
    logic [N_SRC-1:0] clrFlag;
    logic             busySet;
    logic             busyClr;
    logic             audioClr;
  } strobe_t;
endpackage

// File: rtl/icsr_ctrl.sv
`timescale 1ns/1ps
module icsr_ctrl
  import icsr_pkg::*;
(
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             setCop,
  input  logic             setAram,
  input  logic             setAid,
  input  logic             dmaStart,
  input  logic             dmaDone,
  input  logic             busyQ,
  output strobe_t          stb
);
  logic doneEff;
  logic [N_SRC-1:0] srcPulse;

  assign doneEff  = dmaDone & busyQ;
  assign srcPulse = {setAid, setAram | doneEff, setCop};

  always_comb begin
    stb          = '0;
    stb.ctlWr    = wrEn;
    stb.ctlData  = wrData & CTL_BITS;
    stb.setFlag  = srcPulse;
    for (int i = 0; i < N_SRC; i++) begin
      stb.clrFlag[i] = wrEn & wrData[B_FLAG0 + 2*i];
    end
    stb.busySet  = dmaStart;
    stb.busyClr  = doneEff & ~dmaStart;
    stb.audioClr = wrEn & wrData[B_RST];
  end
endmodule

// File: rtl/icsr_dp.sv
`timescale 1ns/1ps
module icsr_dp
  import icsr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  output logic [REG_W-1:0] regWord,
  output logic             busyQ,
  output logic             intQ,
  output logic             audioClrQ
);
  logic [REG_W-1:0] ctlQ;
  logic [N_SRC-1:0] flagQ;
  logic [REG_W-1:0] flagWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ctlQ <= RESET_VAL & CTL_BITS;
    else if (stb.ctlWr) ctlQ <= stb.ctlData;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                flagQ[i] <= 1'b0;
      else if (stb.setFlag[i])  flagQ[i] <= 1'b1;
      else if (stb.clrFlag[i])  flagQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            busyQ <= 1'b0;
    else if (stb.busySet) busyQ <= 1'b1;
    else if (stb.busyClr) busyQ <= 1'b0;
  end

  always_comb begin
    flagWord = '0;
    for (int i = 0; i < N_SRC; i++) flagWord[B_FLAG0 + 2*i] = flagQ[i];
  end

  always_comb begin
    regWord = (ctlQ & CTL_BITS) | flagWord;
    regWord[B_BUSY] = busyQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intQ      <= 1'b0;
      audioClrQ <= 1'b0;
    end else begin
      intQ      <= |((regWord >> 1) & regWord & FLAG_BITS);
      audioClrQ <= stb.audioClr;
    end
  end
endmodule

// File: rtl/icsr_top.sv
`timescale 1ns/1ps
module icsr_top
  import icsr_pkg::*;
#(
  parameter logic [15:0] COP_MASK = 16'h0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  input  logic        setCop,
  input  logic        setAram,
  input  logic        setAid,
  input  logic        dmaStart,
  input  logic        dmaDone,
  input  logic [15:0] copBits,
  output logic [15:0] rdData,
  output logic        intOut,
  output logic        audioDmaClr
);
  strobe_t          stb;
  logic             busyQ;
  logic [REG_W-1:0] regWord;

  icsr_ctrl ctrl_i (
    .wrEn(wrEn), .wrData(wrData), .setCop(setCop), .setAram(setAram),
    .setAid(setAid), .dmaStart(dmaStart), .dmaDone(dmaDone),
    .busyQ(busyQ), .stb(stb)
  );

  icsr_dp dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .regWord(regWord),
    .busyQ(busyQ), .intQ(intOut), .audioClrQ(audioDmaClr)
  );

  assign rdData = (regWord & ~COP_MASK) | (copBits & COP_MASK);
endmodule

// File: rtl/icsr_chk.sv
`timescale 1ns/1ps
module icsr_chk #(
  parameter logic [15:0] COP_MASK = 16'h0000
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [15:0] wrData,
  input logic        setCop,
  input logic        dmaStart,
  input logic        dmaDone,
  input logic [15:0] rdData,
  input logic        intOut,
  input logic        audioDmaClr
);
  AST_INT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    intOut == $past((rdData[4] & rdData[3]) | (rdData[6] & rdData[5]) | (rdData[8] & rdData[7]))); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    setCop |=> rdData[3]); // R5
  AST_W1C: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[3] && !setCop) |=> !rdData[3]); // R4
  AST_AUDIO_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[0]) |=> audioDmaClr); // R7
  AST_AUDIO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrData[0]) |=> !audioDmaClr); // R7
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rstN)
    dmaStart |=> rdData[10]); // R8
  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (dmaDone && rdData[10] && !dmaStart) |=> (!rdData[10] && rdData[5])); // R9
  AST_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (dmaDone && dmaStart && rdData[10]) |=> (rdData[10] && rdData[5])); // R12
  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[15:11] & ~COP_MASK[15:11]) == 5'd0); // R10
endmodule

bind icsr_top icsr_chk #(.COP_MASK(COP_MASK)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .setCop(setCop),
  .dmaStart(dmaStart), .dmaDone(dmaDone), .rdData(rdData),
  .intOut(intOut), .audioDmaClr(audioDmaClr)
);

// File: tb/icsr_top_tb_top.sv
`timescale 1ns/1ps
module icsr_top_tb_top;
  localparam int PERIOD = 8;
  localparam logic [15:0] TB_COP_MASK = 16'h0200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic setCop = 1'b0, setAram = 1'b0, setAid = 1'b0;
  logic dmaStart = 1'b0, dmaDone = 1'b0;
  logic [15:0] copBits = '0;
  logic [15:0] rdData;
  logic intOut, audioDmaClr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  icsr_top #(.COP_MASK(TB_COP_MASK)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .setCop(setCop),
    .setAram(setAram), .setAid(setAid), .dmaStart(dmaStart), .dmaDone(dmaDone),
    .copBits(copBits), .rdData(rdData), .intOut(intOut), .audioDmaClr(audioDmaClr)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    wrEn = 1'b1; wrData = d; step(); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic pulseFlags(input logic [2:0] f);
    setCop = f[0]; setAram = f[1]; setAid = f[2]; step();
    setCop = 1'b0; setAram = 1'b0; setAid = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    chk("R1 reset word", rdData, 16'h0004);
    chk("R1 reset int", {15'd0, intOut}, 16'h0);
    chk("R1 reset clr", {15'd0, audioDmaClr}, 16'h0);
    rstN = 1'b1; step();
    chk("R1 after reset", rdData, 16'h0004);

    // R2 and R7: control bits stored; bit 0 fires the audio clear pulse
    wr(16'h0357);
    chk("R2 control write", rdData, 16'h0157);
    chk("R7 clear pulse", {15'd0, audioDmaClr}, 16'h1);
    step();
    chk("R7 pulse one cycle", {15'd0, audioDmaClr}, 16'h0);
    wr(16'h0000);
    chk("R2 control cleared", rdData, 16'h0000);
    chk("R7 no pulse", {15'd0, audioDmaClr}, 16'h0);

    // R11: coprocessor-owned bit 9 from side input
    copBits = 16'hFFFF; #1;
    chk("R11 merge on", rdData, 16'h0200);
    copBits = 16'h0000; #1;
    chk("R11 merge off", rdData, 16'h0000);

    // R10, R8: read-only and unused bits
    wr(16'hF800);
    chk("R10 high bits", rdData, 16'h0000);
    wr(16'h0400);
    chk("R8 busy not writable", rdData, 16'h0000);

    // R3/R6 sweep over all flag and enable combinations
    for (int f = 0; f < 8; f++) begin
      for (int m = 0; m < 8; m++) begin
        logic [15:0] mw;
        logic [15:0] fw;
        logic expInt;
        mw = {7'd0, m[2], 1'b0, m[1], 1'b0, m[0], 4'd0};
        fw = {8'd0, f[2], 1'b0, f[1], 1'b0, f[0], 3'd0};
        expInt = |(f[2:0] & m[2:0]);
        wr(16'h00A8);
        pulseFlags(f[2:0]);
        wr(mw);
        chk("R3 R2 sweep word", rdData, mw | fw);
        step();
        chk("R6 sweep int", {15'd0, intOut}, {15'd0, expInt});
      end
    end
    wr(16'h00A8);
    chk("R4 clear all", rdData, 16'h0000);
    step();
    chk("R6 int off", {15'd0, intOut}, 16'h0);

    // R3 zero write leaves flags; R4 single clear
    pulseFlags(3'b111);
    wr(16'h0000);
    chk("R3 zero keeps flags", rdData, 16'h00A8);
    wr(16'h0020);
    chk("R4 clear one flag", rdData, 16'h0088);

    // R5 set and clear same cycle
    setAid = 1'b1; wr(16'h0080); setAid = 1'b0;
    chk("R5 set wins", rdData, 16'h0088);
    wr(16'h00A8);

    // R6 one-cycle latency
    wr(16'h0010); step();
    chk("R6 masked idle", {15'd0, intOut}, 16'h0);
    pulseFlags(3'b001);
    chk("R6 flag visible", rdData, 16'h0018);
    chk("R6 int not yet", {15'd0, intOut}, 16'h0);
    step();
    chk("R6 int raised", {15'd0, intOut}, 16'h1);
    wr(16'h0018);
    chk("R6 int held", {15'd0, intOut}, 16'h1);
    step();
    chk("R6 int dropped", {15'd0, intOut}, 16'h0);

    // R8, R9 busy handshake
    dmaStart = 1'b1; step(); dmaStart = 1'b0;
    chk("R8 busy set", rdData, 16'h0410);
    wr(16'h0010);
    chk("R8 busy kept on write", rdData, 16'h0410);
    dmaDone = 1'b1; step(); dmaDone = 1'b0;
    chk("R9 done flag", rdData, 16'h0030);
    wr(16'h0030);
    chk("R4 aram clear", rdData, 16'h0010);
    dmaDone = 1'b1; step(); dmaDone = 1'b0;
    chk("R9 idle done ignored", rdData, 16'h0010);

    // R12 restart in the completion cycle
    dmaStart = 1'b1; step();
    dmaDone = 1'b1; step();
    dmaStart = 1'b0; dmaDone = 1'b0;
    chk("R12 restart", rdData, 16'h0430);
    dmaDone = 1'b1; step(); dmaDone = 1'b0;
    chk("R9 second done", rdData, 16'h0030);

    // R5 completion against write-1-clear
    dmaStart = 1'b1; step(); dmaStart = 1'b0;
    dmaDone = 1'b1; wr(16'h0020); dmaDone = 1'b0;
    chk("R5 done beats clear", rdData, 16'h0020);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule